// File: doc/BRIEF.md
# CAS-before-RAS Refresh and Initialisation Scheduler

This block brings an asynchronous DRAM array out of power-up and keeps its contents alive. After reset it holds all strobes inactive for a programmable power-up pause. It then issues a train of wake-up RAS pulses with CAS held high, and only after the last of them has fully precharged does it declare the array initialised. From then on a free-running interval timer adds one owed refresh every refresh interval. The interval is chosen by a configuration input that picks the 1K-row or the 4K-row organisation.

Owed refreshes are served through a request/grant handshake with the access sequencer. While a refresh is owed and the scheduler is idle, it raises a request. The sequencer answers with a grant once it is idle, with RAS high and its own precharge done. On the grant the scheduler takes the strobes and runs one CAS-before-RAS cycle: a short CAS-high gap, CAS (all lines together) falls, RAS falls, CAS rises after its hold time, RAS rises after its minimum low time, and a full precharge follows. WE stays high. A debt counter keeps up to a parameter number of postponed refreshes and sets a sticky overflow flag when one more falls due while it is full.

States: `ST_PWRUP` (power-up pause) goes to `ST_WAKE_LO` (wake pulse, RAS low), which goes to `ST_WAKE_HI` (wake precharge). `ST_WAKE_HI` returns to `ST_WAKE_LO` until the last pulse, then moves to `ST_IDLE`. On a grant with debt owed, `ST_IDLE` goes to `ST_RPC` (CAS-high gap), then `ST_CSR` (CAS low ahead of RAS), then `ST_CHR` (both low), then `ST_HOLD` (RAS low, CAS high), then `ST_PRE` (precharge), and back to `ST_IDLE`. Every state leaves when its phase timer reaches zero, except `ST_IDLE`, which leaves on the grant.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted, and in the cycle it is released, ras_n=1, every cas_n line=1, we_n=1, and init_done, ref_req, ref_active and debt_ovf are 0.
- R2: After reset release, ras_n stays high until the PWRUP_CYC-th rising clock edge, where it first falls.
- R3: Exactly WAKE_CNT wake pulses follow the pause. Each pulse has RAS low for T_RAS cycles with all CAS lines high, then RAS high for PRE_CYC = max(T_RP, T_RC-T_RAS) cycles. init_done rises right after the last precharge and never falls until reset.
- R4: Once init_done is high, one refresh falls due every REF_INT_1K cycles when cfg_rows4k=0 and every REF_INT_4K cycles when cfg_rows4k=1. The first one falls due that many cycles after init_done rises, and ref_req rises in the same cycle.
- R5: A refresh cycle starts only at a clock edge where ref_gnt and ref_req are both high. A grant while ref_req is low has no effect on ras_n, cas_n or ref_active and does not serve the next owed refresh.
- R6: Taking the grant edge as cycle 0, the refresh cycle runs as follows. The next T_RPC cycles have both strobes high. The next T_CSR have CAS low and RAS high. The next T_CHR have both low. The next T_RAS-T_CHR have RAS low and CAS high. The last PRE_CYC have both high. we_n stays 1 and all N_CAS CAS lines switch together.
- R7: ref_active is high for exactly the refresh cycle of R6, and ref_req is low throughout it.
- R8: Up to DEBT_MAX owed refreshes are kept. ref_req stays high until each of them has been served by its own grant. With ref_gnt held high, exactly DEBT_MAX back-to-back refreshes run.
- R9: When a refresh falls due while DEBT_MAX are already owed, debt_ovf rises in that cycle and stays high until reset. The debt stays at DEBT_MAX.

Ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rows4k | input | 1 | 0: 1K-row interval, 1: 4K-row interval |
| ref_gnt | input | 1 | Grant from the access sequencer (idle, RAS precharged) |
| ref_req | output | 1 | Refresh owed and scheduler idle; blocks new accesses |
| ref_active | output | 1 | Scheduler owns the strobes for a refresh cycle |
| init_done | output | 1 | Power-up pause and wake pulses completed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | N_CAS | Column strobes, active low, switched together |
| we_n | output | 1 | Write enable, held high |
| debt_ovf | output | 1 | Sticky flag: more refreshes fell due than can be owed |

## Verification
Every output is decoded straight from the state register, so each result shows in the cycle after the rising edge that causes it. The bench samples on the falling edge and counts falling edges from a reference sample. The first RAS fall is due PWRUP_CYC samples after reset release. Each wake phase lasts its exact cycle count. ref_req is due exactly one interval of samples after the first init_done sample, and the same interval separates later requests. The overflow is due at nine intervals with the bench's eight-deep debt. Refresh phases are checked sample by sample from the first sample after the grant edge, with the grant dropped in that same sample, so no phase depends on process order at the edge.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_WAKE_LO,
        ST_WAKE_HI,
        ST_IDLE,
        ST_RPC,
        ST_CSR,
        ST_CHR,
        ST_HOLD,
        ST_PRE
    } cbr_state_e;
endpackage

// File: rtl/cbr_phase_timer.sv
// Loadable down-counter; zero marks the last cycle of a phase.
module cbr_phase_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= W'(RST_VAL);
        else if (ld)        cnt <= ld_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/cbr_interval_timer.sv
// Free-running interval counter; one tick per selected period while enabled.
module cbr_interval_timer #(
    parameter int INT_A = 3120,
    parameter int INT_B = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel_b,
    output logic tick
);
    localparam int IMAX = (INT_A > INT_B) ? INT_A : INT_B;
    localparam int IW   = $clog2(IMAX + 1);
    localparam logic [IW-1:0] LAST_A = IW'(INT_A - 1);
    localparam logic [IW-1:0] LAST_B = IW'(INT_B - 1);

    logic [IW-1:0] cnt;
    logic [IW-1:0] last;

    assign last = sel_b ? LAST_B : LAST_A;
    assign tick = en && (cnt >= last);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cbr_debt_counter.sv
// Saturating count of owed refreshes with a sticky overflow flag.
module cbr_debt_counter #(
    parameter int MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic owed,
    output logic ovf
);
    localparam int DW = $clog2(MAX + 1);
    localparam logic [DW-1:0] FULL = DW'(MAX);

    logic [DW-1:0] debt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt <= '0;
            ovf  <= 1'b0;
        end else begin
            unique case ({inc, dec})
                2'b10: begin
                    if (debt != FULL) debt <= debt + 1'b1;
                    else              ovf  <= 1'b1;
                end
                2'b01: if (debt != '0) debt <= debt - 1'b1;
                default: ;
            endcase
        end
    end

    assign owed = (debt != '0);
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
    import cbr_pkg::*;
#(
    parameter int PWRUP_CYC  = 40000,
    parameter int WAKE_CNT   = 8,
    parameter int REF_INT_1K = 3120,
    parameter int REF_INT_4K = 3120,
    parameter int DEBT_MAX   = 8,
    parameter int T_RC       = 22,
    parameter int T_RAS      = 12,
    parameter int T_RP       = 8,
    parameter int T_CSR      = 2,
    parameter int T_CHR      = 2,
    parameter int T_RPC      = 1,
    parameter int N_CAS      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_rows4k,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             ref_active,
    output logic             init_done,
    output logic             ras_n,
    output logic [N_CAS-1:0] cas_n,
    output logic             we_n,
    output logic             debt_ovf
);
    localparam int PRE_CYC = (T_RP > T_RC - T_RAS) ? T_RP : (T_RC - T_RAS);
    localparam int TMAX0   = (PWRUP_CYC > T_RAS) ? PWRUP_CYC : T_RAS;
    localparam int TMAX    = (TMAX0 > PRE_CYC) ? TMAX0 : PRE_CYC;
    localparam int TW      = $clog2(TMAX + 1);
    localparam int WW      = $clog2(WAKE_CNT + 1);

    localparam logic [TW-1:0] LD_RAS  = TW'(T_RAS - 1);
    localparam logic [TW-1:0] LD_PRE  = TW'(PRE_CYC - 1);
    localparam logic [TW-1:0] LD_RPC  = TW'(T_RPC - 1);
    localparam logic [TW-1:0] LD_CSR  = TW'(T_CSR - 1);
    localparam logic [TW-1:0] LD_CHR  = TW'(T_CHR - 1);
    localparam logic [TW-1:0] LD_HOLD = TW'(T_RAS - T_CHR - 1);
    localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CNT - 1);

    cbr_state_e    st, st_nxt;
    logic          tmr_ld, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic [WW-1:0] wake_n;
    logic          wake_last;
    logic          tick, owed, served;
    logic          ras_lo, cas_lo;

    assign wake_last = (wake_n == WAKE_LAST);

    cbr_phase_timer #(.W(TW), .RST_VAL(PWRUP_CYC - 1)) phase_i (
        .clk(clk), .rst_n(rst_n), .ld(tmr_ld), .ld_val(tmr_val), .zero(tmr_zero)
    );

    cbr_interval_timer #(.INT_A(REF_INT_1K), .INT_B(REF_INT_4K)) ivl_i (
        .clk(clk), .rst_n(rst_n), .en(init_done), .sel_b(cfg_rows4k), .tick(tick)
    );

    cbr_debt_counter #(.MAX(DEBT_MAX)) debt_i (
        .clk(clk), .rst_n(rst_n), .inc(tick), .dec(served), .owed(owed), .ovf(debt_ovf)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_PWRUP;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_n <= '0;
        else if (st == ST_WAKE_HI && tmr_zero && !wake_last)
            wake_n <= wake_n + 1'b1;
    end

    // Transitions and phase loads
    always_comb begin
        st_nxt  = st;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        served  = 1'b0;
        unique case (st)
            ST_PWRUP:   if (tmr_zero) begin st_nxt = ST_WAKE_LO; tmr_ld = 1'b1; tmr_val = LD_RAS; end
            ST_WAKE_LO: if (tmr_zero) begin st_nxt = ST_WAKE_HI; tmr_ld = 1'b1; tmr_val = LD_PRE; end
            ST_WAKE_HI: if (tmr_zero) begin
                if (wake_last) st_nxt = ST_IDLE;
                else begin st_nxt = ST_WAKE_LO; tmr_ld = 1'b1; tmr_val = LD_RAS; end
            end
            ST_IDLE:    if (owed && ref_gnt) begin
                st_nxt = ST_RPC; tmr_ld = 1'b1; tmr_val = LD_RPC; served = 1'b1;
            end
            ST_RPC:     if (tmr_zero) begin st_nxt = ST_CSR;  tmr_ld = 1'b1; tmr_val = LD_CSR;  end
            ST_CSR:     if (tmr_zero) begin st_nxt = ST_CHR;  tmr_ld = 1'b1; tmr_val = LD_CHR;  end
            ST_CHR:     if (tmr_zero) begin st_nxt = ST_HOLD; tmr_ld = 1'b1; tmr_val = LD_HOLD; end
            ST_HOLD:    if (tmr_zero) begin st_nxt = ST_PRE;  tmr_ld = 1'b1; tmr_val = LD_PRE;  end
            ST_PRE:     if (tmr_zero) st_nxt = ST_IDLE;
            default:    st_nxt = ST_PWRUP;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        ras_lo     = 1'b0;
        cas_lo     = 1'b0;
        ref_active = 1'b0;
        init_done  = 1'b0;
        ref_req    = 1'b0;
        we_n       = 1'b1;
        unique case (st)
            ST_PWRUP, ST_WAKE_HI: ;
            ST_WAKE_LO: ras_lo = 1'b1;
            ST_IDLE:    begin init_done = 1'b1; ref_req = owed; end
            ST_RPC, ST_PRE: begin init_done = 1'b1; ref_active = 1'b1; end
            ST_CSR:     begin init_done = 1'b1; ref_active = 1'b1; cas_lo = 1'b1; end
            ST_CHR:     begin init_done = 1'b1; ref_active = 1'b1; cas_lo = 1'b1; ras_lo = 1'b1; end
            ST_HOLD:    begin init_done = 1'b1; ref_active = 1'b1; ras_lo = 1'b1; end
            default: ;
        endcase
    end

    assign ras_n = ~ras_lo;

    for (genvar g = 0; g < N_CAS; g++) begin : g_cas
        assign cas_n[g] = ~cas_lo;
    end
endmodule

// File: rtl/cbr_refresh_chk.sv
module cbr_refresh_chk #(
    parameter int T_RAS = 12,
    parameter int T_RP  = 8,
    parameter int T_CSR = 2,
    parameter int T_CHR = 2,
    parameter int N_CAS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_gnt,
    input logic             ref_req,
    input logic             ref_active,
    input logic             init_done,
    input logic             ras_n,
    input logic [N_CAS-1:0] cas_n,
    input logic             debt_ovf
);
    logic [15:0] ras_lo_run, ras_hi_run, cas_lo_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_lo_run <= '0;
            ras_hi_run <= 16'hFFFF;
            cas_lo_run <= '0;
        end else begin
            ras_lo_run <= ras_n ? 16'd0 : ((ras_lo_run == 16'hFFFF) ? ras_lo_run : ras_lo_run + 16'd1);
            ras_hi_run <= !ras_n ? 16'd0 : ((ras_hi_run == 16'hFFFF) ? ras_hi_run : ras_hi_run + 16'd1);
            cas_lo_run <= cas_n[0] ? 16'd0 : ((cas_lo_run == 16'hFFFF) ? cas_lo_run : cas_lo_run + 16'd1);
        end
    end

    a_r3_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r4_no_req_before_init: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_req);

    a_r5_start_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_active) |-> $past(ref_gnt && ref_req));

    a_r6_cas_setup: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n[0] == 1'b0) |-> (cas_lo_run >= 16'(T_CSR)));

    a_r6_cas_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $rose(cas_n[0])) |-> (ras_lo_run >= 16'(T_CHR)));

    a_r6_ras_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_lo_run >= 16'(T_RAS)));

    a_r6_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_hi_run >= 16'(T_RP)));

    a_r7_no_req_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        ref_active |-> !ref_req);

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        debt_ovf |=> debt_ovf);
endmodule

bind cbr_refresh_sched cbr_refresh_chk #(
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR), .T_CHR(T_CHR), .N_CAS(N_CAS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_active(ref_active), .init_done(init_done), .ras_n(ras_n),
    .cas_n(cas_n), .debt_ovf(debt_ovf)
);

// File: tb/cbr_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module cbr_refresh_sched_tb_top;
    localparam int PWRUP = 50;
    localparam int WAKE  = 8;
    localparam int I1K   = 60;
    localparam int I4K   = 400;
    localparam int DMAX  = 8;
    localparam int TRC = 22, TRAS = 12, TRP = 8, TCSR = 2, TCHR = 2, TRPC = 1, NCAS = 8;
    localparam int PRE = (TRP > TRC - TRAS) ? TRP : (TRC - TRAS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_rows4k = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, ref_active, init_done, ras_n, we_n, debt_ovf;
    logic [NCAS-1:0] cas_n;

    int checks = 0;
    int errors = 0;
    int n;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cbr_refresh_sched #(
        .PWRUP_CYC(PWRUP), .WAKE_CNT(WAKE), .REF_INT_1K(I1K), .REF_INT_4K(I4K),
        .DEBT_MAX(DMAX), .T_RC(TRC), .T_RAS(TRAS), .T_RP(TRP), .T_CSR(TCSR),
        .T_CHR(TCHR), .T_RPC(TRPC), .N_CAS(NCAS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_rows4k(cfg_rows4k), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .ref_active(ref_active), .init_done(init_done),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .debt_ovf(debt_ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic check_idle_pins(input string req);
        chk(ras_n === 1'b1, req, int'(ras_n), 1);
        chk(cas_n === '1, req, int'(cas_n), (1 << NCAS) - 1);
        chk(we_n === 1'b1, req, int'(we_n), 1);
        chk(ref_active === 1'b0, req, int'(ref_active), 0);
    endtask

    // R1 reset state, release at a falling edge
    task automatic do_reset(input bit c4);
        cfg_rows4k = c4;
        ref_gnt = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_idle_pins("R1");
        chk(init_done === 1'b0, "R1 init_done", int'(init_done), 0);
        chk(ref_req === 1'b0, "R1 ref_req", int'(ref_req), 0);
        chk(debt_ovf === 1'b0, "R1 debt_ovf", int'(debt_ovf), 0);
        rst_n = 1'b1;
        n = 0;
    endtask

    // R6/R7: grant in the current sample, walk the phases after the grant edge
    task automatic run_refresh();
        int dur [5];
        bit eras [5];
        bit ecas [5];
        dur = '{TRPC, TCSR, TCHR, TRAS - TCHR, PRE};
        eras = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
        ecas = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
        ref_gnt = 1'b1;
        @(negedge clk); n++;
        ref_gnt = 1'b0;
        for (int p = 0; p < 5; p++) begin
            for (int i = 0; i < dur[p]; i++) begin
                chk(ras_n === eras[p], "R6 ras_n phase", int'(ras_n), int'(eras[p]));
                chk(cas_n === {NCAS{ecas[p]}}, "R6 cas_n phase", int'(cas_n), ecas[p] ? (1 << NCAS) - 1 : 0);
                chk(we_n === 1'b1, "R6 we_n", int'(we_n), 1);
                chk(ref_active === 1'b1, "R7 ref_active", int'(ref_active), 1);
                chk(ref_req === 1'b0, "R7 ref_req", int'(ref_req), 0);
                @(negedge clk); n++;
            end
        end
        chk(ref_active === 1'b0, "R7 ref_active end", int'(ref_active), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        finish_run();
    end

    initial begin : main
        int lo, hi, served, s0;
        bit prev;
        // Scenario A: 1K interval
        do_reset(1'b0);
        do begin @(negedge clk); n++; end while (ras_n === 1'b1 && n < 100000);
        chk(n == PWRUP, "R2 first RAS fall", n, PWRUP);
        for (int w = 0; w < WAKE; w++) begin
            lo = 0;
            while (ras_n === 1'b0) begin
                if (cas_n !== '1) chk(1'b0, "R3 CAS high in wake", int'(cas_n), (1 << NCAS) - 1);
                lo++; @(negedge clk);
            end
            chk(lo == TRAS, "R3 wake RAS low", lo, TRAS);
            hi = 0;
            while (ras_n === 1'b1 && init_done !== 1'b1) begin hi++; @(negedge clk); end
            chk(hi == PRE, "R3 wake precharge", hi, PRE);
            chk(init_done === (w == WAKE - 1), "R3 init_done timing", int'(init_done), int'(w == WAKE - 1));
        end
        // R4 first interval, with an unrequested grant (R5) in between
        n = 0;
        while (ref_req !== 1'b1 && n < 100000) begin
            if (n == 5) ref_gnt = 1'b1;
            if (n == 6) ref_gnt = 1'b0;
            @(negedge clk); n++;
            if (n >= 6 && n <= 9) check_idle_pins("R5 grant ignored");
        end
        chk(n == I1K, "R4 1K first request", n, I1K);
        chk(init_done === 1'b1, "R3 init_done sticky", int'(init_done), 1);
        s0 = n;
        run_refresh();
        while (ref_req !== 1'b1 && n < 100000) begin @(negedge clk); n++; end
        chk(n - s0 == I1K, "R4 1K spacing", n - s0, I1K);
        run_refresh();

        // Scenario B: 4K interval, debt and overflow
        do_reset(1'b1);
        while (init_done !== 1'b1 && n < 100000) begin @(negedge clk); n++; end
        n = 0;
        while (ref_req !== 1'b1 && n < 100000) begin @(negedge clk); n++; end
        chk(n == I4K, "R4 4K first request", n, I4K);
        while (debt_ovf !== 1'b1 && n < 100000) begin
            @(negedge clk); n++;
            if (n == (DMAX + 1) * I4K - 1) chk(debt_ovf === 1'b0, "R9 no early overflow", int'(debt_ovf), 0);
        end
        chk(n == (DMAX + 1) * I4K, "R9 overflow time", n, (DMAX + 1) * I4K);
        ref_gnt = 1'b1;
        served = 0;
        prev = 1'b0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk); n++;
            if (ref_active === 1'b1 && !prev) served++;
            prev = ref_active;
            if (ref_active !== 1'b1 && ref_req !== 1'b1) break;
        end
        ref_gnt = 1'b0;
        chk(served == DMAX, "R8 refreshes served", served, DMAX);
        chk(ref_req === 1'b0, "R8 debt cleared", int'(ref_req), 0);
        chk(debt_ovf === 1'b1, "R9 overflow sticky", int'(debt_ovf), 1);
        while (ref_req !== 1'b1 && n < 100000) begin @(negedge clk); n++; end
        chk(n == (DMAX + 2) * I4K, "R8 next request after service", n, (DMAX + 2) * I4K);
        finish_run();
    end
endmodule